// File: doc/BRIEF.md
# Script Processor Start and Phase-Mismatch Control

This block governs when the script engine of a SCSI host adapter runs and where it runs from. It owns the 32-bit script pointer and the running flag. It also holds the wait-for-reselect state and the current 3-bit bus phase. Software programs it through a byte-wide register write port. The engine's own instruction fetcher receives a one-cycle start pulse that carries the pointer to fetch from. The fetcher reports back through a stop input and a wait-enter input.

When the data path detects a phase mismatch, the block does one of two things. If jump redirection is enabled, it reloads the pointer from one of two programmed jump addresses and leaves the engine running. Otherwise it posts a mismatch interrupt and halts the engine. The data path signals a mismatch either directly, or by offering a transfer length check in which the requested count exceeds what the device holds.

All event inputs and the start pulse are single-cycle strobes without back-pressure. The fetcher must accept a start pulse in the cycle it appears, and an event input is consumed in the cycle it is high. Register reads are combinational from the read address.

Top module: `spc_ctrl`

## Requirements
- R1: Pointer bytes are written at offsets 0x00 (least significant) to 0x03 (most significant). A write to 0x03 starts execution only when the manual-start bit (bit 0 of the mode register at 0x10) is clear and the engine is not running. Writes to the other pointer bytes never start it.
- R2: Writing the control register (0x11) with bit 2 set starts the engine if it is idle. Bits 2 and 6 are never stored, so they read back as 0, and the other bits read back as written.
- R3: While waiting (set by a `wait_enter` pulse), a write to 0x12 with bit 5 set does three things: it clears waiting, copies the next-address register (0x04–0x07) into the pointer, and starts execution. When the block is not waiting, the same write has no effect on the pointer or on the running flag.
- R4: On a mismatch with jump enable set (bit 7 of 0x13), the pointer loads jump address A (0x08–0x0B) if jump control (bit 6 of 0x13) is set or the transfer is outbound. Otherwise it loads jump address B (0x0C–0x0F). The running flag is unchanged.
- R5: On a mismatch with jump enable clear, the block sets the mismatch flag (`mismatch_int`, and bit 7 of status 0 at 0x14) and stops the engine.
- R6: On any mismatch the new phase is written to `bus_phase` and to bits 2:0 of 0x15. The phase codes are: data-out 0, data-in 1, command 2, status 3, message-out 6, message-in 7.
- R7: A length check (`len_chk`) with `len_req` greater than `len_avail` is handled as a mismatch. When `len_req` is equal to or less than `len_avail`, nothing changes.
- R8: A write to 0x12 with bit 6 set clears every register of the block, including the pointer, the running flag, the waiting flag, the phase and the mismatch flag. All other effects of that write are ignored.
- R9: The running flag is bit 1 of 0x16. A start request while running is ignored. A stop and a start in the same cycle leave the engine stopped.
- R10: Each start produces a one-cycle `fetch_start` pulse, and `fetch_addr` at that time holds the new pointer value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Byte register write strobe |
| reg_wr_addr | input | 8 | Write byte offset |
| reg_wr_data | input | 8 | Write data |
| reg_rd_addr | input | 8 | Read byte offset |
| reg_rd_data | output | 8 | Read data (combinational) |
| pm_valid | input | 1 | Phase-mismatch event strobe |
| pm_outbound | input | 1 | Transfer direction of the mismatch, 1 = outbound |
| pm_phase | input | 3 | New bus phase of the mismatch |
| len_chk | input | 1 | Length check strobe |
| len_req | input | CNT_W | Requested transfer count |
| len_avail | input | CNT_W | Count the device has available |
| wait_enter | input | 1 | Engine enters wait-for-reselect |
| exec_stop | input | 1 | Engine stop request |
| fetch_start | output | 1 | One-cycle start pulse to the fetcher |
| fetch_addr | output | PTR_W | Pointer to fetch from at start |
| running | output | 1 | Engine running flag |
| waiting | output | 1 | Wait-for-reselect flag |
| bus_phase | output | 3 | Current bus phase |
| mismatch_int | output | 1 | Posted phase-mismatch interrupt |

## Verification
The bench builds the block with PTR_W = 32, which makes every pointer byte lane and the full jump and next-address registers visible through the read port. It uses CNT_W = 8, so the length check can be driven at the exact equal, one-over and full-scale counts. With these widths every branch of the start, stop, wake, redirect and halt priority can be reached in a few hundred cycles.

// File: rtl/spc_pkg.sv
package spc_pkg;
  // 32-bit register blocks, selected by address bits 7:2
  localparam logic [5:0] BLK_PTR  = 6'h00;
  localparam logic [5:0] BLK_NEXT = 6'h01;
  localparam logic [5:0] BLK_JMPA = 6'h02;
  localparam logic [5:0] BLK_JMPB = 6'h03;

  // byte registers
  localparam logic [7:0] REG_MODE  = 8'h10;
  localparam logic [7:0] REG_CTRL  = 8'h11;
  localparam logic [7:0] REG_ISTAT = 8'h12;
  localparam logic [7:0] REG_CC0   = 8'h13;
  localparam logic [7:0] REG_SST0  = 8'h14;
  localparam logic [7:0] REG_SST1  = 8'h15;
  localparam logic [7:0] REG_RUNST = 8'h16;

  // bit positions
  localparam int MODE_MANUAL = 0;
  localparam int CTRL_START  = 2;
  localparam int CTRL_FLUSH  = 6;
  localparam int IST_SIGNAL  = 5;
  localparam int IST_SRESET  = 6;
  localparam int CC0_JCTL    = 6;
  localparam int CC0_JEN     = 7;
  localparam int SST0_MISM   = 7;
  localparam int RUN_BIT     = 1;

  typedef enum logic [2:0] {
    PH_DOUT = 3'd0,
    PH_DIN  = 3'd1,
    PH_CMD  = 3'd2,
    PH_STAT = 3'd3,
    PH_MOUT = 3'd6,
    PH_MIN  = 3'd7
  } phase_e;
endpackage

// File: rtl/spc_byte_reg.sv
module spc_byte_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         we,
  input  logic [1:0]   lane,
  input  logic [7:0]   din,
  output logic [W-1:0] q
);
  localparam int NB = W / 8;

  logic [7:0] b_q [NB];

  for (genvar i = 0; i < NB; i++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          b_q[i] <= '0;
      else if (clr)                        b_q[i] <= '0;
      else if (we && (lane == 2'(i)))      b_q[i] <= din;
    end
    assign q[i*8 +: 8] = b_q[i];
  end
endmodule

// File: rtl/spc_pm_sel.sv
module spc_pm_sel #(
  parameter int W = 32
) (
  input  logic         jump_en,
  input  logic         jump_ctl,
  input  logic         outbound,
  input  logic [W-1:0] addr_a,
  input  logic [W-1:0] addr_b,
  output logic         redirect,
  output logic [W-1:0] target
);
  assign redirect = jump_en;
  assign target   = (jump_ctl || outbound) ? addr_a : addr_b;
endmodule

// File: rtl/spc_run_ctl.sv
module spc_run_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic stop,
  input  logic start,
  output logic running,
  output logic start_pulse
);
  logic go;
  assign go = start && !stop && !clr && !running;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running     <= 1'b0;
      start_pulse <= 1'b0;
    end else begin
      start_pulse <= go;
      if (clr || stop) running <= 1'b0;
      else if (go)     running <= 1'b1;
    end
  end

  p_busy_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |-> !$past(running));

  p_stop_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> !running);
endmodule

// File: rtl/spc_ctrl.sv
module spc_ctrl
  import spc_pkg::*;
#(
  parameter int PTR_W = 32,
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr_en,
  input  logic [7:0]       reg_wr_addr,
  input  logic [7:0]       reg_wr_data,
  input  logic [7:0]       reg_rd_addr,
  output logic [7:0]       reg_rd_data,
  input  logic             pm_valid,
  input  logic             pm_outbound,
  input  logic [2:0]       pm_phase,
  input  logic             len_chk,
  input  logic [CNT_W-1:0] len_req,
  input  logic [CNT_W-1:0] len_avail,
  input  logic             wait_enter,
  input  logic             exec_stop,
  output logic             fetch_start,
  output logic [PTR_W-1:0] fetch_addr,
  output logic             running,
  output logic             waiting,
  output logic [2:0]       bus_phase,
  output logic             mismatch_int
);
  localparam int NB = PTR_W / 8;

  // ---------------- write decode ----------------
  logic [5:0] wr_blk;
  logic [1:0] wr_lane;
  assign wr_blk  = reg_wr_addr[7:2];
  assign wr_lane = reg_wr_addr[1:0];

  logic ptr_we, nxt_we, ja_we, jb_we;
  logic mode_we, ctrl_we, ist_we, cc0_we;
  assign ptr_we  = reg_wr_en && (wr_blk == BLK_PTR);
  assign nxt_we  = reg_wr_en && (wr_blk == BLK_NEXT);
  assign ja_we   = reg_wr_en && (wr_blk == BLK_JMPA);
  assign jb_we   = reg_wr_en && (wr_blk == BLK_JMPB);
  assign mode_we = reg_wr_en && (reg_wr_addr == REG_MODE);
  assign ctrl_we = reg_wr_en && (reg_wr_addr == REG_CTRL);
  assign ist_we  = reg_wr_en && (reg_wr_addr == REG_ISTAT);
  assign cc0_we  = reg_wr_en && (reg_wr_addr == REG_CC0);

  // ---------------- state ----------------
  logic [PTR_W-1:0] ptr_q, ptr_d;
  logic [PTR_W-1:0] nxt_q, ja_q, jb_q;
  logic [7:0]       mode_q, ctrl_q, cc0_q;
  logic             wait_q, mism_q;
  logic [2:0]       phase_q;

  // ---------------- events ----------------
  logic sreset, wake, len_over, pm_trig, pm_jump, pm_halt;
  logic redirect;
  logic [PTR_W-1:0] jmp_target;
  logic ptr_msb_wr, start_req, stop_req;

  assign sreset     = ist_we && reg_wr_data[IST_SRESET];
  assign wake       = ist_we && !sreset && wait_q && reg_wr_data[IST_SIGNAL];
  assign len_over   = len_chk && (len_req > len_avail);
  assign pm_trig    = (pm_valid || len_over) && !sreset;
  assign pm_jump    = pm_trig && redirect;
  assign pm_halt    = pm_trig && !redirect;
  assign ptr_msb_wr = ptr_we && (int'(wr_lane) == NB - 1);
  assign start_req  = !sreset &&
                      ((ptr_msb_wr && !mode_q[MODE_MANUAL]) ||
                       (ctrl_we && reg_wr_data[CTRL_START]) ||
                       wake);
  assign stop_req   = exec_stop || pm_halt;

  // ---------------- sub-blocks ----------------
  spc_byte_reg #(.W(PTR_W)) u_next (
    .clk(clk), .rst_n(rst_n), .clr(sreset), .we(nxt_we),
    .lane(wr_lane), .din(reg_wr_data), .q(nxt_q));

  spc_byte_reg #(.W(PTR_W)) u_jmpa (
    .clk(clk), .rst_n(rst_n), .clr(sreset), .we(ja_we),
    .lane(wr_lane), .din(reg_wr_data), .q(ja_q));

  spc_byte_reg #(.W(PTR_W)) u_jmpb (
    .clk(clk), .rst_n(rst_n), .clr(sreset), .we(jb_we),
    .lane(wr_lane), .din(reg_wr_data), .q(jb_q));

  spc_pm_sel #(.W(PTR_W)) u_sel (
    .jump_en(cc0_q[CC0_JEN]), .jump_ctl(cc0_q[CC0_JCTL]),
    .outbound(pm_outbound), .addr_a(ja_q), .addr_b(jb_q),
    .redirect(redirect), .target(jmp_target));

  spc_run_ctl u_run (
    .clk(clk), .rst_n(rst_n), .clr(sreset), .stop(stop_req),
    .start(start_req), .running(running), .start_pulse(fetch_start));

  // ---------------- pointer ----------------
  always_comb begin
    ptr_d = ptr_q;
    if (ptr_we && (int'(wr_lane) < NB))
      ptr_d[int'(wr_lane)*8 +: 8] = reg_wr_data;
    if (wake)    ptr_d = nxt_q;
    if (pm_jump) ptr_d = jmp_target;
    if (sreset)  ptr_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q      <= '0;
      fetch_addr <= '0;
    end else begin
      ptr_q <= ptr_d;
      if (start_req) fetch_addr <= ptr_d;
    end
  end

  // ---------------- byte control registers ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      ctrl_q <= '0;
      cc0_q  <= '0;
    end else if (sreset) begin
      mode_q <= '0;
      ctrl_q <= '0;
      cc0_q  <= '0;
    end else begin
      if (mode_we) mode_q <= reg_wr_data;
      if (ctrl_we) begin
        ctrl_q             <= reg_wr_data;
        ctrl_q[CTRL_START] <= 1'b0;
        ctrl_q[CTRL_FLUSH] <= 1'b0;
      end
      if (cc0_we)  cc0_q  <= reg_wr_data;
    end
  end

  // ---------------- wait, phase, mismatch flag ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wait_q  <= 1'b0;
      mism_q  <= 1'b0;
      phase_q <= PH_DOUT;
    end else if (sreset) begin
      wait_q  <= 1'b0;
      mism_q  <= 1'b0;
      phase_q <= PH_DOUT;
    end else begin
      if (wake)            wait_q <= 1'b0;
      else if (wait_enter) wait_q <= 1'b1;
      if (pm_halt)         mism_q <= 1'b1;
      if (pm_trig)         phase_q <= pm_phase;
    end
  end

  assign waiting      = wait_q;
  assign bus_phase    = phase_q;
  assign mismatch_int = mism_q;

  // ---------------- read port ----------------
  function automatic logic [7:0] pick_byte(input logic [PTR_W-1:0] v,
                                           input logic [1:0] l);
    pick_byte = (int'(l) < NB) ? v[int'(l)*8 +: 8] : 8'h00;
  endfunction

  always_comb begin
    reg_rd_data = 8'h00;
    case (reg_rd_addr[7:2])
      BLK_PTR:  reg_rd_data = pick_byte(ptr_q, reg_rd_addr[1:0]);
      BLK_NEXT: reg_rd_data = pick_byte(nxt_q, reg_rd_addr[1:0]);
      BLK_JMPA: reg_rd_data = pick_byte(ja_q,  reg_rd_addr[1:0]);
      BLK_JMPB: reg_rd_data = pick_byte(jb_q,  reg_rd_addr[1:0]);
      default: begin
        case (reg_rd_addr)
          REG_MODE:  reg_rd_data = mode_q;
          REG_CTRL:  reg_rd_data = ctrl_q;
          REG_CC0:   reg_rd_data = cc0_q;
          REG_SST0:  reg_rd_data = {mism_q, 7'b0};
          REG_SST1:  reg_rd_data = {5'b0, phase_q};
          REG_RUNST: reg_rd_data = {6'b0, running, 1'b0};
          default:   reg_rd_data = 8'h00;
        endcase
      end
    endcase
  end

  // ---------------- assertions ----------------
  p_manual_blocks_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_msb_wr && mode_q[MODE_MANUAL] && !ctrl_we && !wake) |=> !fetch_start);

  p_wake_loads_next_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wake && !pm_jump) |=> (!waiting && ptr_q == $past(nxt_q)));

  p_jump_target_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pm_jump |=> (ptr_q == (($past(cc0_q[CC0_JCTL]) || $past(pm_outbound))
                           ? $past(ja_q) : $past(jb_q))));

  p_nojump_halt_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pm_halt |=> (!running && mismatch_int));

  p_phase_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pm_trig |=> (bus_phase == $past(pm_phase)));

  p_soft_reset_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sreset |=> (ptr_q == '0 && !running && !waiting && !mismatch_int));

  p_pulse_carries_ptr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_start |-> (running && fetch_addr == ptr_q));

  p_pulse_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_start |=> !fetch_start);
endmodule

// File: tb/spc_ctrl_tb.sv
`timescale 1ns/1ps
module spc_ctrl_tb;
  localparam int PTR_W = 32;
  localparam int CNT_W = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             reg_wr_en = 1'b0;
  logic [7:0]       reg_wr_addr = '0;
  logic [7:0]       reg_wr_data = '0;
  logic [7:0]       reg_rd_addr = '0;
  logic [7:0]       reg_rd_data;
  logic             pm_valid = 1'b0;
  logic             pm_outbound = 1'b0;
  logic [2:0]       pm_phase = '0;
  logic             len_chk = 1'b0;
  logic [CNT_W-1:0] len_req = '0;
  logic [CNT_W-1:0] len_avail = '0;
  logic             wait_enter = 1'b0;
  logic             exec_stop = 1'b0;
  logic             fetch_start;
  logic [PTR_W-1:0] fetch_addr;
  logic             running;
  logic             waiting;
  logic [2:0]       bus_phase;
  logic             mismatch_int;

  spc_ctrl #(.PTR_W(PTR_W), .CNT_W(CNT_W)) u_dut (.*);

  always #10 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_wr_addr = a; reg_wr_data = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic stop_pulse();
    @(negedge clk);
    exec_stop = 1'b1;
    @(negedge clk);
    exec_stop = 1'b0;
  endtask

  task automatic rd8(input logic [7:0] a, output logic [7:0] d);
    reg_rd_addr = a;
    #1;
    d = reg_rd_data;
  endtask

  task automatic rd_ptr(input logic [7:0] base, output logic [31:0] v);
    logic [7:0] b;
    for (int i = 0; i < 4; i++) begin
      rd8(base + 8'(i), b);
      v[i*8 +: 8] = b;
    end
  endtask

  task automatic mismatch(input logic outb, input logic [2:0] ph);
    @(negedge clk);
    pm_valid = 1'b1; pm_outbound = outb; pm_phase = ph;
    @(negedge clk);
    pm_valid = 1'b0;
  endtask

  task automatic wr32(input logic [7:0] base, input logic [31:0] v);
    for (int i = 0; i < 4; i++) wr(base + 8'(i), v[i*8 +: 8]);
  endtask

  // vector: op[51:50] (0 write, 1 stop) addr[49:42] data[41:34]
  //         exp_running[33] exp_start[32] exp_ptr[31:0]
  localparam int NV = 12;
  localparam logic [51:0] VEC [NV] = '{
    {2'd0, 8'h00, 8'h40, 1'b0, 1'b0, 32'h0000_0040},  // R1 low byte, no start
    {2'd0, 8'h01, 8'h12, 1'b0, 1'b0, 32'h0000_1240},  // R1
    {2'd0, 8'h02, 8'h34, 1'b0, 1'b0, 32'h0034_1240},  // R1
    {2'd0, 8'h03, 8'h80, 1'b1, 1'b1, 32'h8034_1240},  // R1 MSB start, R10
    {2'd0, 8'h03, 8'h81, 1'b1, 1'b0, 32'h8134_1240},  // R9 start while running
    {2'd1, 8'h00, 8'h00, 1'b0, 1'b0, 32'h8134_1240},  // R9 stop
    {2'd0, 8'h10, 8'h01, 1'b0, 1'b0, 32'h8134_1240},  // R1 manual mode on
    {2'd0, 8'h03, 8'h82, 1'b0, 1'b0, 32'h8234_1240},  // R1 manual blocks start
    {2'd0, 8'h11, 8'h04, 1'b1, 1'b1, 32'h8234_1240},  // R2 control start
    {2'd1, 8'h00, 8'h00, 1'b0, 1'b0, 32'h8234_1240},  // R9 stop
    {2'd0, 8'h10, 8'h00, 1'b0, 1'b0, 32'h8234_1240},  // R1 manual off
    {2'd0, 8'h00, 8'h7F, 1'b0, 1'b0, 32'h8234_127F}   // R1 low byte, no start
  };

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    logic [31:0] p;
    logic [7:0]  b;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state (R8 defaults)
    chk("R8 reset running", 32'(running), 32'd0);
    chk("R8 reset waiting", 32'(waiting), 32'd0);
    chk("R6 reset phase", 32'(bus_phase), 32'd0);
    chk("R5 reset mismatch", 32'(mismatch_int), 32'd0);
    rd_ptr(8'h00, p);
    chk("R8 reset pointer", p, 32'h0);

    // vector table walk
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][51:50] == 2'd1) stop_pulse();
      else wr(VEC[i][49:42], VEC[i][41:34]);
      chk($sformatf("R9 vec%0d running", i), 32'(running), 32'(VEC[i][33]));
      chk($sformatf("R10 vec%0d fetch_start", i), 32'(fetch_start), 32'(VEC[i][32]));
      rd_ptr(8'h00, p);
      chk($sformatf("R1 vec%0d pointer", i), p, VEC[i][31:0]);
      if (VEC[i][32]) chk($sformatf("R10 vec%0d fetch_addr", i), fetch_addr, VEC[i][31:0]);
    end
    @(negedge clk);
    chk("R10 pulse one cycle", 32'(fetch_start), 32'd0);

    // R2 stored bits
    wr(8'h11, 8'h44);
    rd8(8'h11, b);
    chk("R2 start/flush not stored", 32'(b), 32'h00);
    chk("R2 start bit starts", 32'(running), 32'd1);
    rd8(8'h16, b);
    chk("R9 running bit1 readback", 32'(b), 32'h02);
    stop_pulse();
    wr(8'h11, 8'h81);
    rd8(8'h11, b);
    chk("R2 other bits stored", 32'(b), 32'h81);

    // R4 jump redirection
    wr32(8'h08, 32'h1000_0100);
    wr32(8'h0C, 32'h2000_0200);
    wr(8'h13, 8'h80);
    mismatch(1'b0, 3'd1);
    rd_ptr(8'h00, p);
    chk("R4 inbound ctl0 -> B", p, 32'h2000_0200);
    chk("R6 phase data-in", 32'(bus_phase), 32'd1);
    chk("R4 no interrupt on jump", 32'(mismatch_int), 32'd0);
    mismatch(1'b1, 3'd0);
    rd_ptr(8'h00, p);
    chk("R4 outbound -> A", p, 32'h1000_0100);
    wr(8'h13, 8'hC0);
    mismatch(1'b0, 3'd7);
    rd_ptr(8'h00, p);
    chk("R4 jump control -> A", p, 32'h1000_0100);
    rd8(8'h15, b);
    chk("R6 status1 message-in", 32'(b), 32'h07);

    // R7 length check, jump to B
    wr(8'h13, 8'h80);
    wr(8'h00, 8'h55);
    @(negedge clk);
    len_chk = 1'b1; len_req = 8'd5; len_avail = 8'd5; pm_outbound = 1'b0; pm_phase = 3'd2;
    @(negedge clk);
    len_chk = 1'b0;
    rd_ptr(8'h00, p);
    chk("R7 equal count no mismatch", p, 32'h1000_0155);
    chk("R7 equal count phase kept", 32'(bus_phase), 32'd7);
    @(negedge clk);
    len_chk = 1'b1; len_req = 8'd255; len_avail = 8'd254;
    @(negedge clk);
    len_chk = 1'b0;
    rd_ptr(8'h00, p);
    chk("R7 over count -> B", p, 32'h2000_0200);
    chk("R7 phase command", 32'(bus_phase), 32'd2);

    // R5 halt without jump
    wr(8'h13, 8'h00);
    wr(8'h11, 8'h04);
    chk("R5 running before", 32'(running), 32'd1);
    mismatch(1'b1, 3'd3);
    chk("R5 stopped", 32'(running), 32'd0);
    chk("R5 interrupt posted", 32'(mismatch_int), 32'd1);
    rd8(8'h14, b);
    chk("R5 status0 bit7", 32'(b), 32'h80);
    chk("R6 phase status", 32'(bus_phase), 32'd3);
    rd_ptr(8'h00, p);
    chk("R5 pointer kept", p, 32'h2000_0200);

    // R3 wake from wait
    wr(8'h12, 8'h20);
    rd_ptr(8'h00, p);
    chk("R3 signal ignored when not waiting", p, 32'h2000_0200);
    chk("R3 no start when not waiting", 32'(running), 32'd0);
    wr32(8'h04, 32'h0000_3000);
    @(negedge clk); wait_enter = 1'b1;
    @(negedge clk); wait_enter = 1'b0;
    chk("R3 waiting set", 32'(waiting), 32'd1);
    wr(8'h12, 8'h20);
    chk("R3 waiting cleared", 32'(waiting), 32'd0);
    chk("R3 started", 32'(running), 32'd1);
    chk("R10 wake pulse", 32'(fetch_start), 32'd1);
    chk("R10 wake fetch_addr", fetch_addr, 32'h0000_3000);
    rd_ptr(8'h00, p);
    chk("R3 pointer from next", p, 32'h0000_3000);

    // R9 stop and start together
    stop_pulse();
    @(negedge clk);
    exec_stop = 1'b1; reg_wr_en = 1'b1; reg_wr_addr = 8'h11; reg_wr_data = 8'h04;
    @(negedge clk);
    exec_stop = 1'b0; reg_wr_en = 1'b0;
    chk("R9 stop+start stays stopped", 32'(running), 32'd0);
    chk("R9 stop+start no pulse", 32'(fetch_start), 32'd0);

    // R8 soft reset
    wr(8'h10, 8'h01);
    wr(8'h13, 8'hC0);
    wr(8'h11, 8'h04);
    @(negedge clk); wait_enter = 1'b1;
    @(negedge clk); wait_enter = 1'b0;
    wr(8'h12, 8'h60);
    chk("R8 running cleared", 32'(running), 32'd0);
    chk("R8 waiting cleared", 32'(waiting), 32'd0);
    chk("R8 mismatch cleared", 32'(mismatch_int), 32'd0);
    chk("R8 phase cleared", 32'(bus_phase), 32'd0);
    chk("R8 no wake pulse", 32'(fetch_start), 32'd0);
    rd_ptr(8'h00, p);
    chk("R8 pointer cleared", p, 32'h0);
    rd_ptr(8'h08, p);
    chk("R8 jump A cleared", p, 32'h0);
    rd8(8'h10, b);
    chk("R8 mode cleared", 32'(b), 32'h0);
    rd8(8'h13, b);
    chk("R8 chip control cleared", 32'(b), 32'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule